// File: doc/BRIEF.md
# UART Interrupt Source Combiner

This block merges the event strobes of a UART into one interrupt-source pulse for the system interrupt controller. Four causes can raise the pulse. The first is the end of a transmission, which the block detects as the falling edge of the transmit-busy level. The other three are receive events: a telegram was received, a break was seen, or the received address matched. The transmit cause always raises the pulse and leaves no record. Each receive cause raises the pulse only when its bit in the mask register is set. An enabled break or address match also sets a sticky flag. An enabled received-telegram event sets its flag only when the receive FIFO was empty before that telegram.

The receive side is organised around telegrams, and the end-of-telegram marker closes each one. Within one telegram the receive causes raise the pulse at most once, however many of them occur. A flag set during a telegram stays visible until the end of the following telegram. It is then cleared, or it keeps its value if the same event occurs again. Software can clear any flag at any time by writing a one to it.

Top module: `uart_irq_combiner`

## Requirements
- R1: Reset clears `irq_o`, all flags and all mask bits. The mask and flag vectors use the same bit positions: bit 0 is received telegram, bit 1 is break, bit 2 is address match.
- R2: When `mask_we_i` is high at a clock edge, `mask_o` takes the value of `mask_wdata_i` after that edge.
- R3: A falling edge of `tx_busy_i` makes `irq_o` high in the next cycle, whatever the mask holds. It changes no flag.
- R4: A receive strobe whose mask bit is clear neither raises `irq_o` nor sets a flag.
- R5: An enabled `brk_i` sets flag bit 1 after the edge, and an enabled `adr_i` sets flag bit 2, each also raising `irq_o` in the next cycle unless R6 blocks it.
- R6: Receive strobes raise `irq_o` at most once per telegram. A telegram ends with the cycle in which `eot_i` is high, and strobes in that cycle belong to the telegram that is ending.
- R7: An enabled `rx_tel_i` sets flag bit 0 only if `fifo_was_empty_i` is high in the same cycle. It raises `irq_o` either way, subject to R6.
- R8: A flag set during one telegram stays set until the end of the next telegram. At that `eot_i` it is cleared, unless the event sets it again in that same telegram.
- R9: A one on bit k of `flag_clr_i` clears flag k after the edge. A set of the same flag in the same cycle wins over the clear.
- R10: A transmit-done edge and an enabled receive strobe in the same cycle produce a single `irq_o` pulse one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_busy_i | input | 1 | Transmitter busy level |
| rx_tel_i | input | 1 | Received-telegram strobe |
| brk_i | input | 1 | Break-detected strobe |
| adr_i | input | 1 | Address-match strobe |
| fifo_was_empty_i | input | 1 | Receive FIFO was empty before this telegram |
| eot_i | input | 1 | End-of-telegram marker |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 3 | Mask write data |
| flag_clr_i | input | 3 | Write-one-to-clear for flags |
| mask_o | output | 3 | Mask register contents |
| flags_o | output | 3 | Sticky flag register |
| irq_o | output | 1 | One-cycle interrupt-source pulse |

## Verification
A stuck once-per-telegram latch shows in the cycle after the next enabled receive strobe. It then gives either a missing pulse at the start of a new telegram or a second pulse within the same telegram. A wrong aging bit shows at `flags_o` one telegram late: the flag survives past the second `eot_i`, or it is gone before the end of the first one. A lost edge register on the transmit-busy level shows as a missing pulse one cycle after busy drops, or as an extra one.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned NUM_EV  = 3;
  localparam int unsigned EV_RCVD = 0;
  localparam int unsigned EV_BRK  = 1;
  localparam int unsigned EV_ADR  = 2;
  typedef logic [NUM_EV-1:0] ev_vec_t;
endpackage

// File: rtl/uart_irq_txedge.sv
module uart_irq_txedge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  output logic done_o
);
  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= busy_i;
  end

  assign done_o = busy_q & ~busy_i;
endmodule

// File: rtl/uart_irq_flags.sv
module uart_irq_flags
  import uart_irq_pkg::*;
#(
  parameter int unsigned N = NUM_EV
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         eot_i,
  output logic [N-1:0] flags_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    logic vis_q, cur_q, vis_d, cur_d, base;

    // at eot, only what this telegram set survives into the next one
    always_comb begin
      base  = eot_i ? cur_q : vis_q;
      vis_d = (base & ~clr_i[k]) | set_i[k];
      cur_d = eot_i ? 1'b0 : ((cur_q & ~clr_i[k]) | set_i[k]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vis_q <= 1'b0;
        cur_q <= 1'b0;
      end else begin
        vis_q <= vis_d;
        cur_q <= cur_d;
      end
    end

    assign flags_o[k] = vis_q;
  end
endmodule

// File: rtl/uart_irq_gate.sv
module uart_irq_gate
  import uart_irq_pkg::*;
#(
  parameter int unsigned N = NUM_EV
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] hit_i,
  input  logic         tx_done_i,
  input  logic         eot_i,
  output logic         irq_o
);
  logic fired_q, irq_q, rx_hit, rx_fire;

  assign rx_hit  = |hit_i;
  assign rx_fire = rx_hit & ~fired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fired_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      fired_q <= eot_i ? 1'b0 : (fired_q | rx_hit);
      irq_q   <= tx_done_i | rx_fire;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/uart_irq_combiner.sv
module uart_irq_combiner
  import uart_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_busy_i,
  input  logic              rx_tel_i,
  input  logic              brk_i,
  input  logic              adr_i,
  input  logic              fifo_was_empty_i,
  input  logic              eot_i,
  input  logic              mask_we_i,
  input  logic [NUM_EV-1:0] mask_wdata_i,
  input  logic [NUM_EV-1:0] flag_clr_i,
  output logic [NUM_EV-1:0] mask_o,
  output logic [NUM_EV-1:0] flags_o,
  output logic              irq_o
);
  ev_vec_t mask_q, ev, hit, set;
  logic    tx_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_wdata_i;
  end

  always_comb begin
    ev          = '0;
    ev[EV_RCVD] = rx_tel_i;
    ev[EV_BRK]  = brk_i;
    ev[EV_ADR]  = adr_i;
    hit         = ev & mask_q;
    set         = hit;
    set[EV_RCVD] = hit[EV_RCVD] & fifo_was_empty_i;
  end

  uart_irq_txedge u_txedge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .busy_i(tx_busy_i),
    .done_o(tx_done)
  );

  uart_irq_flags #(.N(NUM_EV)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set),
    .clr_i  (flag_clr_i),
    .eot_i  (eot_i),
    .flags_o(flags_o)
  );

  uart_irq_gate #(.N(NUM_EV)) u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (hit),
    .tx_done_i(tx_done),
    .eot_i    (eot_i),
    .irq_o    (irq_o)
  );

  assign mask_o = mask_q;
endmodule

// File: rtl/uart_irq_combiner_chk.sv
module uart_irq_combiner_chk
  import uart_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_busy_i,
  input logic              rx_tel_i,
  input logic              brk_i,
  input logic              adr_i,
  input logic              mask_we_i,
  input logic [NUM_EV-1:0] mask_wdata_i,
  input logic [NUM_EV-1:0] flag_clr_i,
  input logic [NUM_EV-1:0] mask_o,
  input logic [NUM_EV-1:0] flags_o,
  input logic              irq_o
);
  logic [1:0] up_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end

  // R2
  mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> (mask_o == $past(mask_wdata_i)));

  // R3
  tx_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_cnt >= 2'd1 && $fell(tx_busy_i)) |=> irq_o);

  // R4
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_cnt >= 2'd2 && irq_o) |->
      (($past(tx_busy_i, 2) && !$past(tx_busy_i)) ||
       ($past({adr_i, brk_i, rx_tel_i} & mask_o) != '0)));

  // R5
  brk_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_cnt >= 2'd1 && $rose(flags_o[1])) |-> $past(brk_i && mask_o[1]));

  // R9
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_clr_i != '0) && !rx_tel_i && !brk_i && !adr_i) |=>
      ((flags_o & $past(flag_clr_i)) == '0));
endmodule

bind uart_irq_combiner uart_irq_combiner_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_busy_i   (tx_busy_i),
  .rx_tel_i    (rx_tel_i),
  .brk_i       (brk_i),
  .adr_i       (adr_i),
  .mask_we_i   (mask_we_i),
  .mask_wdata_i(mask_wdata_i),
  .flag_clr_i  (flag_clr_i),
  .mask_o      (mask_o),
  .flags_o     (flags_o),
  .irq_o       (irq_o)
);

// File: tb/uart_irq_combiner_tb.sv
module uart_irq_combiner_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_busy = 1'b0, rx_tel = 1'b0, brk = 1'b0, adr = 1'b0;
  logic       fifo_empty = 1'b0, eot = 1'b0, mask_we = 1'b0;
  logic [2:0] mask_wdata = '0, flag_clr = '0;
  logic [2:0] mask, flags;
  logic       irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_combiner u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_busy_i(tx_busy), .rx_tel_i(rx_tel),
    .brk_i(brk), .adr_i(adr), .fifo_was_empty_i(fifo_empty), .eot_i(eot),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wdata), .flag_clr_i(flag_clr),
    .mask_o(mask), .flags_o(flags), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle();
    {rx_tel, brk, adr, fifo_empty, eot, mask_we} = '0;
    flag_clr = '0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    chk("R1 irq", {2'b0, irq}, 3'b000);
    chk("R1 flags", flags, 3'b000);
    chk("R1 mask", mask, 3'b000);
  endtask

  task automatic t_mask(input logic [2:0] v);
    mask_we = 1'b1; mask_wdata = v;
    step();
    chk("R2 mask", mask, v);
  endtask

  task automatic t_tx();
    tx_busy = 1'b1; step(); step();
    chk("R3 no irq while busy", {2'b0, irq}, 3'b000);
    tx_busy = 1'b0; step();
    chk("R3 irq after fall", {2'b0, irq}, 3'b001);
    step();
    chk("R3 pulse one cycle", {2'b0, irq}, 3'b000);
    chk("R3 flags untouched", flags, 3'b000);
  endtask

  task automatic t_masked();
    brk = 1'b1; adr = 1'b1; rx_tel = 1'b1; fifo_empty = 1'b1; step();
    chk("R4 masked irq", {2'b0, irq}, 3'b000);
    chk("R4 masked flags", flags, 3'b000);
    eot = 1'b1; step(); step();
    chk("R4 masked flags after eot", flags, 3'b000);
  endtask

  task automatic t_telegrams();
    brk = 1'b1; step();
    chk("R5 brk irq", {2'b0, irq}, 3'b001);
    chk("R5 brk flag", flags, 3'b010);
    adr = 1'b1; step();
    chk("R6 second event no irq", {2'b0, irq}, 3'b000);
    chk("R5 adr flag", flags, 3'b110);
    rx_tel = 1'b1; fifo_empty = 1'b0; eot = 1'b1; step();
    chk("R6 rcvd same telegram no irq", {2'b0, irq}, 3'b000);
    chk("R7 no rcvd flag when fifo not empty", flags, 3'b110);
    step();
    chk("R8 flags persist into next telegram", flags, 3'b110);
    rx_tel = 1'b1; fifo_empty = 1'b1; eot = 1'b1; step();
    chk("R6 new telegram fires", {2'b0, irq}, 3'b001);
    chk("R8 old flags replaced at next eot", flags, 3'b001);
    eot = 1'b1; step();
    chk("R8 flag cleared after following eot", flags, 3'b000);
  endtask

  task automatic t_clear();
    brk = 1'b1; step();
    chk("R9 set before clear", flags, 3'b010);
    flag_clr = 3'b010; step();
    chk("R9 clear", flags, 3'b000);
    brk = 1'b1; flag_clr = 3'b010; step();
    chk("R9 set wins over clear", flags, 3'b010);
    eot = 1'b1; step(); eot = 1'b1; step();
    chk("R8 cleared after two eot", flags, 3'b000);
  endtask

  task automatic t_coincide();
    tx_busy = 1'b1; step();
    tx_busy = 1'b0; adr = 1'b1; step();
    chk("R10 one pulse", {2'b0, irq}, 3'b001);
    step();
    chk("R10 pulse ends", {2'b0, irq}, 3'b000);
    eot = 1'b1; step();
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_mask(3'b101);
    t_mask(3'b000);
    t_tx();
    t_masked();
    t_mask(3'b111);
    t_telegrams();
    t_clear();
    t_coincide();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule